// File: doc/BRIEF.md
# Segmented Address Translation Unit

The unit holds a small file of segment registers and turns a segment number plus an offset into a linear address. In real mode a segment register is loaded directly: its cached base becomes sixteen times the selector value, and a translation adds the low 16 offset bits to that base inside a 1 MB space. In protected mode a selector load is split into a descriptor index, a table bit and a requested privilege level. The unit fetches a simplified 64-bit descriptor from the global or local table over a request/response port, checks it, and caches its base, limit and privilege in the hidden part of the target register.

Translations never wait for the descriptor port. They use whatever the hidden part holds at the strobe and return the address, the selector in use and a limit fault one cycle later. A selector load that faults leaves the target register as it was.

Top module: `seg_xlate`

## Requirements
- R1: A selector carries the descriptor index in bits 15..3, the table bit in bit 2 (0 = global table, 1 = local table) and the requested privilege in bits 1..0. The descriptor read address is the chosen table base plus the index times 8.
- R2: A protected-mode load with index 0 pulses `ld_fault_o` one cycle after it is accepted and issues no descriptor read.
- R3: A fetched descriptor whose privilege is numerically lower than the requested privilege makes the load fault. Equal values, or a requested value numerically below the descriptor's, pass.
- R4: The descriptor word holds the base in bits 31..0, the limit in bits 51..32 and the privilege in bits 53..52. A passing load writes the selector and these three fields into the target register and pulses `ld_done_o` in the cycle after the response.
- R5: A load that faults leaves both the selector and the cached part of the target register unchanged.
- R6: `dr_valid_o` holds with a stable address until `dr_ready_i` is high. `busy_o` is high from the cycle after a protected load is accepted until its result pulse. Loads offered while busy are ignored. Done and fault never pulse together.
- R7: In protected mode a translation returns base plus offset modulo 2^32, together with the segment's selector, one cycle after `xl_valid_i`.
- R8: In protected mode `xl_fault_o` is set when the offset is greater than the cached limit. An offset equal to the limit does not fault.
- R9: A real-mode load sets the selector, sets the base to 16 times the selector and the limit to 0xFFFF, pulses `ld_done_o` the next cycle and issues no descriptor read.
- R10: A real-mode translation returns (base + offset[15:0]) modulo 2^20 and never faults.
- R11: After reset every segment register has selector 0, base 0 and limit 0xFFFF. The exception is the code segment (parameter `CODE_SEG`), which holds selector 0xF000 and base 0xF0000, so offset 0xFFF0 reaches 0xFFFF0.
- R12: A write with `tbl_wr_i` loads `tbl_base_i` into the local table base when `tbl_local_i` is 1, and into the global table base when it is 0. Both bases reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_mode_i | input | 1 | 1 = protected mode, 0 = real mode |
| tbl_wr_i | input | 1 | Table base write strobe |
| tbl_local_i | input | 1 | Selects the local (1) or global (0) table base |
| tbl_base_i | input | 32 | Table base value to write |
| ld_valid_i | input | 1 | Selector load strobe |
| ld_seg_i | input | SEG_W | Target segment register |
| ld_sel_i | input | 16 | Selector value to load |
| busy_o | output | 1 | Descriptor fetch in progress |
| ld_done_o | output | 1 | Load completed (pulse) |
| ld_fault_o | output | 1 | Load rejected (pulse) |
| dr_valid_o | output | 1 | Descriptor read request valid |
| dr_addr_o | output | 32 | Descriptor read address |
| dr_ready_i | input | 1 | Descriptor read request accepted |
| dr_rvalid_i | input | 1 | Descriptor response valid |
| dr_rdata_i | input | 64 | Descriptor response word |
| xl_valid_i | input | 1 | Translate strobe |
| xl_seg_i | input | SEG_W | Segment register to translate through |
| xl_off_i | input | 32 | Offset |
| xl_valid_o | output | 1 | Translation result valid |
| xl_addr_o | output | 32 | Linear address |
| xl_sel_o | output | 16 | Selector of the segment used |
| xl_fault_o | output | 1 | Offset beyond limit |

## Verification
The bench builds the unit with its defaults: four segment registers, code segment 0 and reset selector 0xF000. Four registers are enough to hold a passing load, a privilege-faulted load and a null load side by side and to observe through translations that each one kept or changed its own base. The default reset selector makes the 0xFFFF0 start address reachable. The descriptor model stalls its ready for a cycle and answers two cycles later, so the busy window is long enough to offer an ignored second load inside it.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEL_W   = 16;
  localparam int IDX_W   = 13;
  localparam int RPL_W   = 2;
  localparam int ADDR_W  = 32;
  localparam int LIM_W   = 20;
  localparam int DESC_W  = 64;
  localparam int REAL_W  = 20;
  localparam int ROFF_W  = 16;
  localparam int D_LIM_LSB = 32;
  localparam int D_DPL_LSB = 52;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [RPL_W-1:0]  dpl;
  } hid_t;

  function automatic hid_t unpack_desc(input logic [D_DPL_LSB+RPL_W-1:0] w);
    hid_t h;
    h.base  = w[ADDR_W-1:0];
    h.limit = w[D_LIM_LSB+LIM_W-1:D_LIM_LSB];
    h.dpl   = w[D_DPL_LSB+RPL_W-1:D_DPL_LSB];
    return h;
  endfunction
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_xlate_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  output logic [RPL_W-1:0]  rpl_o,
  output logic              null_o,
  output logic [ADDR_W-1:0] desc_addr_o
);
  logic [IDX_W-1:0]  idx;
  logic              tbl;
  logic [ADDR_W-1:0] base;

  assign idx    = sel_i[SEL_W-1:3];
  assign tbl    = sel_i[2];
  assign rpl_o  = sel_i[RPL_W-1:0];
  assign null_o = (idx == '0);
  assign base   = tbl ? ldt_base_i : gdt_base_i;
  // 8-byte descriptors
  assign desc_addr_o = base + {{(ADDR_W-IDX_W-3){1'b0}}, idx, 3'b000};
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prot_i,
  input  logic              ld_valid_i,
  input  logic [SEG_W-1:0]  ld_seg_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  input  logic [RPL_W-1:0]  rpl_i,
  input  logic              null_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  output logic              dr_valid_o,
  output logic [ADDR_W-1:0] dr_addr_o,
  input  logic              dr_ready_i,
  input  logic              dr_rvalid_i,
  input  logic [DESC_W-1:0] dr_rdata_i,
  output logic              wr_en_o,
  output logic [SEG_W-1:0]  wr_seg_o,
  output logic [SEL_W-1:0]  wr_sel_o,
  output hid_t              wr_hid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} st_e;

  st_e               st_q;
  logic [SEG_W-1:0]  seg_q;
  logic [SEL_W-1:0]  sel_q;
  logic [RPL_W-1:0]  rpl_q;
  logic [ADDR_W-1:0] addr_q;
  hid_t              desc;
  logic              accept, real_ld, null_ld, rsp, priv_ok;
  logic [DESC_W-D_DPL_LSB-RPL_W-1:0] unused_rsvd;

  assign unused_rsvd = dr_rdata_i[DESC_W-1:D_DPL_LSB+RPL_W];
  assign desc    = unpack_desc(dr_rdata_i[D_DPL_LSB+RPL_W-1:0]);
  assign accept  = (st_q == ST_IDLE) && ld_valid_i;
  assign real_ld = accept && !prot_i;
  assign null_ld = accept && prot_i && null_i;
  assign rsp     = (st_q == ST_RSP) && dr_rvalid_i;
  assign priv_ok = (rpl_q <= desc.dpl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      seg_q   <= '0;
      sel_q   <= '0;
      rpl_q   <= '0;
      addr_q  <= '0;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      done_o  <= real_ld || (rsp && priv_ok);
      fault_o <= null_ld || (rsp && !priv_ok);
      unique case (st_q)
        ST_IDLE: if (accept && prot_i && !null_i) begin
          st_q   <= ST_REQ;
          seg_q  <= ld_seg_i;
          sel_q  <= ld_sel_i;
          rpl_q  <= rpl_i;
          addr_q <= desc_addr_i;
        end
        ST_REQ:  if (dr_ready_i) st_q <= ST_RSP;
        ST_RSP:  if (dr_rvalid_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en_o  = 1'b0;
    wr_seg_o = seg_q;
    wr_sel_o = sel_q;
    wr_hid_o = desc;
    if (real_ld) begin
      wr_en_o        = 1'b1;
      wr_seg_o       = ld_seg_i;
      wr_sel_o       = ld_sel_i;
      wr_hid_o.base  = {{(ADDR_W-SEL_W-4){1'b0}}, ld_sel_i, 4'h0};
      wr_hid_o.limit = LIM_W'(20'h0FFFF);
      wr_hid_o.dpl   = '0;
    end else if (rsp && priv_ok) begin
      wr_en_o = 1'b1;
    end
  end

  assign dr_valid_o = (st_q == ST_REQ);
  assign dr_addr_o  = addr_q;
  assign busy_o     = (st_q != ST_IDLE);
endmodule

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int              NUM_SEGS = 4,
  parameter int              SEG_W    = 2,
  parameter int              CODE_SEG = 0,
  parameter logic [SEL_W-1:0] CODE_SEL = 16'hF000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEG_W-1:0] wr_seg_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  hid_t             wr_hid_i,
  input  logic [SEG_W-1:0] rd_seg_i,
  output logic [SEL_W-1:0] rd_sel_o,
  output hid_t             rd_hid_o
);
  logic [SEL_W-1:0] sel_w [NUM_SEGS];
  hid_t             hid_w [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    localparam logic [SEL_W-1:0]  RST_SEL  = (g == CODE_SEG) ? CODE_SEL : '0;
    localparam logic [ADDR_W-1:0] RST_BASE = {{(ADDR_W-SEL_W-4){1'b0}}, RST_SEL, 4'h0};
    logic [SEL_W-1:0] sel_q;
    hid_t             hid_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q       <= RST_SEL;
        hid_q.base  <= RST_BASE;
        hid_q.limit <= LIM_W'(20'h0FFFF);
        hid_q.dpl   <= '0;
      end else if (wr_en_i && (wr_seg_i == SEG_W'(g))) begin
        sel_q <= wr_sel_i;
        hid_q <= wr_hid_i;
      end
    end
    assign sel_w[g] = sel_q;
    assign hid_w[g] = hid_q;
  end

  assign rd_sel_o = sel_w[rd_seg_i];
  assign rd_hid_o = hid_w[rd_seg_i];
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prot_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  hid_t              hid_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              fault_o
);
  logic [REAL_W-1:0] real_sum;
  logic [ADDR_W-1:0] prot_sum;
  logic              over;
  logic [RPL_W-1:0]  unused_dpl;

  assign unused_dpl = hid_i.dpl;
  assign real_sum   = hid_i.base[REAL_W-1:0] + {{(REAL_W-ROFF_W){1'b0}}, off_i[ROFF_W-1:0]};
  assign prot_sum   = hid_i.base + off_i;
  assign over       = off_i > {{(ADDR_W-LIM_W){1'b0}}, hid_i.limit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      sel_o   <= '0;
      fault_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        addr_o  <= prot_i ? prot_sum : {{(ADDR_W-REAL_W){1'b0}}, real_sum};
        sel_o   <= sel_i;
        fault_o <= prot_i && over;
      end
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int               NUM_SEGS = 4,
  parameter int               CODE_SEG = 0,
  parameter logic [SEL_W-1:0] CODE_SEL = 16'hF000,
  localparam int              SEG_W    = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prot_mode_i,
  input  logic              tbl_wr_i,
  input  logic              tbl_local_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              ld_valid_i,
  input  logic [SEG_W-1:0]  ld_seg_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  output logic              busy_o,
  output logic              ld_done_o,
  output logic              ld_fault_o,
  output logic              dr_valid_o,
  output logic [ADDR_W-1:0] dr_addr_o,
  input  logic              dr_ready_i,
  input  logic              dr_rvalid_i,
  input  logic [DESC_W-1:0] dr_rdata_i,
  input  logic              xl_valid_i,
  input  logic [SEG_W-1:0]  xl_seg_i,
  input  logic [ADDR_W-1:0] xl_off_i,
  output logic              xl_valid_o,
  output logic [ADDR_W-1:0] xl_addr_o,
  output logic [SEL_W-1:0]  xl_sel_o,
  output logic              xl_fault_o
);
  logic [ADDR_W-1:0] gdt_q, ldt_q, desc_addr;
  logic [RPL_W-1:0]  rpl;
  logic              is_null, wr_en;
  logic [SEG_W-1:0]  wr_seg;
  logic [SEL_W-1:0]  wr_sel, rd_sel;
  hid_t              wr_hid, rd_hid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gdt_q <= '0;
      ldt_q <= '0;
    end else if (tbl_wr_i) begin
      if (tbl_local_i) ldt_q <= tbl_base_i;
      else             gdt_q <= tbl_base_i;
    end
  end

  seg_sel_decode i_dec (
    .sel_i(ld_sel_i), .gdt_base_i(gdt_q), .ldt_base_i(ldt_q),
    .rpl_o(rpl), .null_o(is_null), .desc_addr_o(desc_addr)
  );

  seg_desc_fetch #(.SEG_W(SEG_W)) i_fetch (
    .clk_i, .rst_ni, .prot_i(prot_mode_i),
    .ld_valid_i, .ld_seg_i, .ld_sel_i, .rpl_i(rpl), .null_i(is_null),
    .desc_addr_i(desc_addr),
    .dr_valid_o, .dr_addr_o, .dr_ready_i, .dr_rvalid_i, .dr_rdata_i,
    .wr_en_o(wr_en), .wr_seg_o(wr_seg), .wr_sel_o(wr_sel), .wr_hid_o(wr_hid),
    .busy_o, .done_o(ld_done_o), .fault_o(ld_fault_o)
  );

  seg_regfile #(
    .NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W), .CODE_SEG(CODE_SEG), .CODE_SEL(CODE_SEL)
  ) i_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_seg_i(wr_seg), .wr_sel_i(wr_sel), .wr_hid_i(wr_hid),
    .rd_seg_i(xl_seg_i), .rd_sel_o(rd_sel), .rd_hid_o(rd_hid)
  );

  seg_addr_gen i_agen (
    .clk_i, .rst_ni, .prot_i(prot_mode_i),
    .valid_i(xl_valid_i), .off_i(xl_off_i), .sel_i(rd_sel), .hid_i(rd_hid),
    .valid_o(xl_valid_o), .addr_o(xl_addr_o), .sel_o(xl_sel_o), .fault_o(xl_fault_o)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_xlate_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prot_mode_i,
  input logic              busy_o,
  input logic              ld_done_o,
  input logic              ld_fault_o,
  input logic              dr_valid_o,
  input logic              dr_ready_i,
  input logic [ADDR_W-1:0] dr_addr_o,
  input logic              xl_valid_i,
  input logic              xl_valid_o,
  input logic [ADDR_W-1:0] xl_addr_o
);
  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_valid_o && !dr_ready_i |=> dr_valid_o && $stable(dr_addr_o));

  assert_req_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_valid_o |-> busy_o);

  assert_result_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_done_o || ld_fault_o) |-> !busy_o);

  assert_done_xor_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_done_o && ld_fault_o));

  assert_xl_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_valid_o |-> $past(xl_valid_i));

  assert_real_1mb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_valid_o && !$past(prot_mode_i) |-> xl_addr_o[ADDR_W-1:REAL_W] == '0);
endmodule

bind seg_xlate seg_xlate_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prot_mode_i(prot_mode_i),
  .busy_o(busy_o), .ld_done_o(ld_done_o), .ld_fault_o(ld_fault_o),
  .dr_valid_o(dr_valid_o), .dr_ready_i(dr_ready_i), .dr_addr_o(dr_addr_o),
  .xl_valid_i(xl_valid_i), .xl_valid_o(xl_valid_o), .xl_addr_o(xl_addr_o)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot = 1'b0;
  logic        tbl_wr = 1'b0, tbl_local = 1'b0;
  logic [31:0] tbl_base = '0;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic        busy, ld_done, ld_fault, dr_valid;
  logic [31:0] dr_addr;
  logic        dr_ready = 1'b0, dr_rvalid = 1'b0;
  logic [63:0] dr_rdata = '0;
  logic        xl_valid = 1'b0;
  logic [1:0]  xl_seg = '0;
  logic [31:0] xl_off = '0;
  logic        xl_valid_o, xl_fault;
  logic [31:0] xl_addr;
  logic [15:0] xl_sel;

  always #2 clk = ~clk;

  seg_xlate i_seg_xlate (
    .clk_i(clk), .rst_ni(rst_n), .prot_mode_i(prot),
    .tbl_wr_i(tbl_wr), .tbl_local_i(tbl_local), .tbl_base_i(tbl_base),
    .ld_valid_i(ld_valid), .ld_seg_i(ld_seg), .ld_sel_i(ld_sel),
    .busy_o(busy), .ld_done_o(ld_done), .ld_fault_o(ld_fault),
    .dr_valid_o(dr_valid), .dr_addr_o(dr_addr), .dr_ready_i(dr_ready),
    .dr_rvalid_i(dr_rvalid), .dr_rdata_i(dr_rdata),
    .xl_valid_i(xl_valid), .xl_seg_i(xl_seg), .xl_off_i(xl_off),
    .xl_valid_o(xl_valid_o), .xl_addr_o(xl_addr), .xl_sel_o(xl_sel), .xl_fault_o(xl_fault)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // descriptor memory model: one stall cycle before ready, answer two cycles later
  logic [63:0] dmem [logic [31:0]];
  int          m_st = 0, m_cnt = 0, req_cnt = 0;
  logic [31:0] req_addr = '0, m_addr = '0;

  function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [19:0] l,
                                          input logic [1:0] d);
    return {10'b0, d, l, b};
  endfunction

  always @(negedge clk) begin
    dr_ready  = 1'b0;
    dr_rvalid = 1'b0;
    case (m_st)
      0: if (dr_valid) m_st = 1;
      1: begin
        dr_ready = 1'b1; m_addr = dr_addr; req_addr = dr_addr;
        req_cnt++; m_cnt = 2; m_st = 2;
      end
      default: begin
        m_cnt--;
        if (m_cnt == 0) begin
          dr_rvalid = 1'b1;
          dr_rdata  = dmem.exists(m_addr) ? dmem[m_addr] : 64'h0;
          m_st = 0;
        end
      end
    endcase
  end

  // scoreboard
  logic [31:0] q_addr [$];
  logic [15:0] q_sel  [$];
  logic        q_flt  [$];
  string       q_tag  [$];

  always @(negedge clk) begin
    if (rst_n && xl_valid_o) begin
      if (q_addr.size() == 0) begin
        chk(1'b0, "R7", "unexpected result", {32'b0, xl_addr}, 64'h0);
      end else begin
        logic [31:0] ea; logic [15:0] es; logic ef; string t;
        ea = q_addr.pop_front(); es = q_sel.pop_front();
        ef = q_flt.pop_front();  t  = q_tag.pop_front();
        chk(xl_addr == ea,  t, "addr",  {32'b0, xl_addr}, {32'b0, ea});
        chk(xl_sel == es,   t, "sel",   {48'b0, xl_sel},  {48'b0, es});
        chk(xl_fault == ef, t, "fault", {63'b0, xl_fault}, {63'b0, ef});
      end
    end
  end

  task automatic xl(input logic [1:0] s, input logic [31:0] off, input logic [31:0] ea,
                    input logic [15:0] es, input logic ef, input string tag);
    @(negedge clk);
    xl_valid = 1'b1; xl_seg = s; xl_off = off;
    q_addr.push_back(ea); q_sel.push_back(es); q_flt.push_back(ef); q_tag.push_back(tag);
    @(negedge clk);
    xl_valid = 1'b0;
  endtask

  task automatic tbl(input logic loc, input logic [31:0] b);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_local = loc; tbl_base = b;
    @(negedge clk);
    tbl_wr = 1'b0;
  endtask

  // exp_rd: 1 if a descriptor read at exp_a must occur
  task automatic load(input logic [1:0] s, input logic [15:0] sel, input bit exp_flt,
                      input bit exp_rd, input logic [31:0] exp_a, input string tag);
    int c0, n;
    c0 = req_cnt;
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = s; ld_sel = sel;
    @(negedge clk);
    ld_valid = 1'b0;
    if (exp_rd) chk(busy && !ld_done && !ld_fault, "R6", "busy after accept",
                    {63'b0, busy}, 64'h1);
    n = 0;
    while (!(ld_done || ld_fault) && n < 50) begin
      @(negedge clk); n++;
    end
    chk(ld_fault == exp_flt && ld_done == !exp_flt, tag, "load result {done,fault}",
        {62'b0, ld_done, ld_fault}, {62'b0, !exp_flt, exp_flt});
    chk(req_cnt - c0 == (exp_rd ? 1 : 0), tag, "descriptor reads",
        64'(req_cnt - c0), 64'(exp_rd ? 1 : 0));
    if (exp_rd) chk(req_addr == exp_a, "R1", "descriptor address",
                    {32'b0, req_addr}, {32'b0, exp_a});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !dr_valid && !xl_valid_o && !ld_done && !ld_fault, "R11",
        "idle outputs after reset", {59'b0, busy, dr_valid, xl_valid_o, ld_done, ld_fault}, 64'h0);

    // R11 reset contents, real mode
    xl(2'd0, 32'h0000_FFF0, 32'h000F_FFF0, 16'hF000, 1'b0, "R11");
    xl(2'd1, 32'h0000_1234, 32'h0000_1234, 16'h0000, 1'b0, "R11");
    xl(2'd2, 32'h0000_0000, 32'h0000_0000, 16'h0000, 1'b0, "R11");

    // R9 real-mode load, R10 wrap and offset truncation
    load(2'd1, 16'h1234, 1'b0, 1'b0, 32'h0, "R9");
    xl(2'd1, 32'h0000_0010, 32'h0001_2350, 16'h1234, 1'b0, "R9");
    load(2'd2, 16'hFFFF, 1'b0, 1'b0, 32'h0, "R9");
    xl(2'd2, 32'h0000_FFFF, 32'h0000_FFEF, 16'hFFFF, 1'b0, "R10");
    xl(2'd1, 32'h0001_0010, 32'h0001_2350, 16'h1234, 1'b0, "R10");

    // protected mode setup, R12
    dmem[32'h0000_1008] = mk_desc(32'h0040_0000, 20'h00FFF, 2'd0);
    dmem[32'h0000_8008] = mk_desc(32'h0002_0000, 20'h0FFFF, 2'd3);
    dmem[32'h0000_1010] = mk_desc(32'h0300_0000, 20'h000FF, 2'd2);
    dmem[32'h0000_1018] = mk_desc(32'hFFFF_FF00, 20'hFFFFF, 2'd1);
    @(negedge clk); prot = 1'b1;
    tbl(1'b0, 32'h0000_1000);
    tbl(1'b1, 32'h0000_8000);

    // R1/R4 global index 1, R7 translation, R8 limit edges
    load(2'd1, 16'h0008, 1'b0, 1'b1, 32'h0000_1008, "R4");
    xl(2'd1, 32'h0000_0010, 32'h0040_0010, 16'h0008, 1'b0, "R7");
    xl(2'd1, 32'h0000_0FFF, 32'h0040_0FFF, 16'h0008, 1'b0, "R8");
    xl(2'd1, 32'h0000_1000, 32'h0040_1000, 16'h0008, 1'b1, "R8");

    // R3 privilege fault; R5 segment unchanged
    load(2'd1, 16'h000B, 1'b1, 1'b1, 32'h0000_1008, "R3");
    xl(2'd1, 32'h0000_0010, 32'h0040_0010, 16'h0008, 1'b0, "R5");

    // R1/R12 local table
    load(2'd2, 16'h000F, 1'b0, 1'b1, 32'h0000_8008, "R12");
    xl(2'd2, 32'h0000_0020, 32'h0002_0020, 16'h000F, 1'b0, "R12");

    // R3 equal privilege passes, lower descriptor privilege faults
    load(2'd3, 16'h0012, 1'b0, 1'b1, 32'h0000_1010, "R3");
    xl(2'd3, 32'h0000_00FF, 32'h0300_00FF, 16'h0012, 1'b0, "R3");
    load(2'd3, 16'h001A, 1'b1, 1'b1, 32'h0000_1018, "R3");
    xl(2'd3, 32'h0000_0100, 32'h0300_0100, 16'h0012, 1'b1, "R5");

    // R2 null selectors, either table
    load(2'd1, 16'h0004, 1'b1, 1'b0, 32'h0, "R2");
    load(2'd1, 16'h0000, 1'b1, 1'b0, 32'h0, "R2");
    xl(2'd1, 32'h0000_0010, 32'h0040_0010, 16'h0008, 1'b0, "R5");

    // R7 wrap modulo 2^32
    load(2'd0, 16'h0019, 1'b0, 1'b1, 32'h0000_1018, "R4");
    xl(2'd0, 32'h0000_0200, 32'h0000_0100, 16'h0019, 1'b0, "R7");

    // R6 load offered while busy is ignored
    begin
      int n;
      @(negedge clk); ld_valid = 1'b1; ld_seg = 2'd2; ld_sel = 16'h0010;
      @(negedge clk); ld_valid = 1'b0;
      chk(busy, "R6", "busy during fetch", {63'b0, busy}, 64'h1);
      @(negedge clk); ld_valid = 1'b1; ld_seg = 2'd2; ld_sel = 16'h0000;
      @(negedge clk); ld_valid = 1'b0;
      n = 0;
      while (!(ld_done || ld_fault) && n < 50) begin @(negedge clk); n++; end
      chk(ld_done && !ld_fault, "R6", "first load completes",
          {62'b0, ld_done, ld_fault}, 64'h2);
      repeat (3) begin
        @(negedge clk);
        chk(!ld_done && !ld_fault, "R6", "ignored load gives no result",
            {62'b0, ld_done, ld_fault}, 64'h0);
      end
      xl(2'd2, 32'h0000_0005, 32'h0300_0005, 16'h0010, 1'b0, "R6");
    end

    repeat (4) @(negedge clk);
    chk(q_addr.size() == 0, "R7", "results outstanding", 64'(q_addr.size()), 64'h0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R6", "watchdog expired", 64'h0, 64'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule